// File: doc/BRIEF.md
# Buffered Serial Transceiver with Programmable Sample Point

This block is an asynchronous serial transmitter and receiver for a chip's peripheral bus. Software writes characters into a 16-entry transmit queue and reads received characters from a 16-entry receive queue. A register port with a 6-bit byte offset carries the accesses. A single configuration word sets the character length (5 to 8 bits), the parity mode and one or two stop bits. It also holds the bit period, as a count of system clocks in its upper 24 bits.

The receiver's sample point is set by its own register. It gives the clock count within each bit period at which the line is read, so the sample point does not follow from the bit period. Software normally programs about half the bit period, and at least 7. Seven interrupt conditions are latched in a pending register. Each condition can be routed to one or both of two interrupt lines by its own enable mask.

Top module: `sio_uart`

## Requirements
- R1: Configuration word at offset 0x00: bits 31:8 give the bit period in clock cycles, bit 7 is the global enable, bit 6 the receive enable and bit 5 the transmit enable. The configuration word resets to 0 and reads back as written.
- R2: A transmitted frame has a low start bit, then the data bits least significant first, with the count set by configuration bits 1:0 (0→5, 1→6, 2→7, 3→8). The line is high when no frame is being sent. Writing offset 0x10 queues the low byte.
- R3: With configuration bit 4 set, a parity bit follows the data. Bit 3 = 1 selects even parity, so the data bits plus the parity bit hold an even number of ones. Bit 3 = 0 selects odd parity.
- R4: Configuration bit 2 selects two stop bits (high) instead of one.
- R5: The sample register at offset 0x08 resets to 7. The receiver reads the line when the count within each bit period equals this value. A falling edge starts a frame only if the line is still low at that point. Received characters read at offset 0x14 in bits 7:0, with unused upper data bits zero.
- R6: Status at offset 0x18: bit 3 transmit queue empty, bit 2 transmit queue full, bit 1 receive queue empty, bit 0 receive queue full.
- R7: Each queue holds 16 characters and delivers them in arrival order.
- R8: A write to 0x10 while the transmit queue is full is discarded and sets pending bit 0.
- R9: A read of 0x14 while the receive queue is empty returns the last character taken and sets pending bit 4.
- R10: A character that completes while the receive queue is full is discarded and sets pending bit 3.
- R11: A wrong parity bit sets pending bit 2 and a low stop bit sets pending bit 1. The character is still stored.
- R12: Pending bit 6 is set while the receive queue is non-empty and bit 5 while the transmit queue is empty. Pending reads at 0x24 and 0x28. Writing 1s to 0x24 clears bits, and writing 1s to 0x28 sets them. 0x2C reads pending ANDed with the OR of both masks. The irq0 output is high when pending & mask 0x1C is non-zero, and irq1 likewise with mask 0x20.
- R13: With the global or transmit enable clear, the line stays high and queued characters are kept. With the global or receive enable clear, the line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid the next cycle |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line |
| irq0 | output | 1 | Interrupt through mask at 0x1C |
| irq1 | output | 1 | Interrupt through mask at 0x20 |

## Verification
A corrupted bit counter or shift register in the transmitter shows up within one frame as a wrong bit, a missing parity bit or a stop bit out of place at the line sample points. A wrong sample count in the receiver returns a wrong character on the very next read. The bench checks this by holding each data bit at its wrong value for the early part of its period. Queue pointer faults appear as full or empty flags in the wrong state, or as characters out of order, by the sixteenth access. A fault in the pending logic shows on the interrupt lines in the cycle after the event.

// File: rtl/sio_pkg.sv
// Shared offsets, interrupt bit indices and frame-format type for the serial transceiver.
// Assumes a 6-bit byte offset on the register port.
package sio_pkg;
    localparam logic [5:0] OFF_CFG  = 6'h00;
    localparam logic [5:0] OFF_SAMP = 6'h08;
    localparam logic [5:0] OFF_TXD  = 6'h10;
    localparam logic [5:0] OFF_RXD  = 6'h14;
    localparam logic [5:0] OFF_STAT = 6'h18;
    localparam logic [5:0] OFF_IEN0 = 6'h1C;
    localparam logic [5:0] OFF_IEN1 = 6'h20;
    localparam logic [5:0] OFF_PCLR = 6'h24;
    localparam logic [5:0] OFF_PSET = 6'h28;
    localparam logic [5:0] OFF_MSKD = 6'h2C;

    localparam int NUM_IRQ   = 7;
    localparam int IRQ_TXOVR = 0;
    localparam int IRQ_STOPE = 1;
    localparam int IRQ_PARE  = 2;
    localparam int IRQ_RXOVR = 3;
    localparam int IRQ_RXUND = 4;
    localparam int IRQ_TXE   = 5;
    localparam int IRQ_RXNE  = 6;

    typedef struct packed {
        logic       par_en;
        logic       par_even;
        logic       two_stop;
        logic [1:0] len;
    } frame_cfg_t;

    // Number of data bits for a length code.
    function automatic logic [3:0] data_bits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction
endpackage

// File: rtl/sio_fifo.sv
// Synchronous first-in first-out queue.
// Assumes DEPTH is a power of two; the caller never pushes when full nor pops when empty.
module sio_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign dout  = mem[rp[AW-1:0]];

    // Store pushed data.
    always_ff @(posedge clk) begin
        if (push) mem[wp[AW-1:0]] <= din;
    end

    // Advance pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n) !(push && full));
    a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n) !(pop && empty));
endmodule

// File: rtl/sio_tx.sv
// Transmit shifter: takes one character from the queue when idle and sends start,
// data (LSB first), optional parity and stop bits, each lasting baud clock cycles.
// Assumes the frame format is stable while a frame is in flight.
module sio_tx #(
    parameter int CW = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [CW-1:0]       baud,
    input  sio_pkg::frame_cfg_t fcfg,
    input  logic                have_data,
    input  logic [7:0]          data,
    output logic                take,
    output logic                line
);
    localparam int FW = 12;

    logic          busy;
    logic [CW-1:0] cnt;
    logic [FW-1:0] sh, frame;
    logic [3:0]    left, nb, total;
    logic [7:0]    md;
    logic          par;

    // Assemble the frame for the character at the queue head.
    always_comb begin
        nb    = sio_pkg::data_bits(fcfg.len);
        md    = data & (8'hFF >> (2'd3 - fcfg.len));
        par   = (^md) ^ ~fcfg.par_even;
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < int'(nb)) frame[1 + i] = md[i];
        end
        if (fcfg.par_en) frame[4'd1 + nb] = par;
        total = 4'd2 + nb + {3'b000, fcfg.par_en} + {3'b000, fcfg.two_stop};
    end

    assign take = en && !busy && have_data;
    assign line = busy ? sh[0] : 1'b1;

    // Bit timing and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            sh   <= '1;
            left <= '0;
        end else if (take) begin
            busy <= 1'b1;
            cnt  <= '0;
            sh   <= frame;
            left <= total;
        end else if (busy) begin
            if (cnt == baud - CW'(1)) begin
                cnt  <= '0;
                sh   <= {1'b1, sh[FW-1:1]};
                left <= left - 4'd1;
                if (left == 4'd1) busy <= 1'b0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    a_r1_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |-> $stable(line));
endmodule

// File: rtl/sio_rx.sv
// Receive shifter: synchronises the line, validates the start bit at the sample point
// and collects data, parity and stop bits, reporting one completed character per frame.
// Assumes samp < baud.
module sio_rx #(
    parameter int CW = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [CW-1:0]       baud,
    input  logic [CW-1:0]       samp,
    input  sio_pkg::frame_cfg_t fcfg,
    input  logic                line,
    output logic                done,
    output logic [7:0]          data,
    output logic                perr,
    output logic                serr
);
    logic          s1, s2, act, perr_acc, serr_acc;
    logic [CW-1:0] cnt;
    logic [3:0]    idx, nb, last;
    logic [7:0]    sh;
    logic          hit;

    // Frame geometry from the format.
    always_comb begin
        nb   = sio_pkg::data_bits(fcfg.len);
        last = nb + 4'd1 + {3'b000, fcfg.par_en} + {3'b000, fcfg.two_stop};
        hit  = (cnt == samp);
    end

    // Two-stage line synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= line;
            s2 <= s1;
        end
    end

    // Frame reception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act      <= 1'b0;
            cnt      <= '0;
            idx      <= '0;
            sh       <= '0;
            perr_acc <= 1'b0;
            serr_acc <= 1'b0;
            done     <= 1'b0;
            data     <= '0;
            perr     <= 1'b0;
            serr     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!act) begin
                if (en && !s2) begin
                    act      <= 1'b1;
                    cnt      <= '0;
                    idx      <= '0;
                    sh       <= '0;
                    perr_acc <= 1'b0;
                    serr_acc <= 1'b0;
                end
            end else begin
                if (cnt == baud - CW'(1)) begin
                    cnt <= '0;
                    idx <= idx + 4'd1;
                end else begin
                    cnt <= cnt + CW'(1);
                end
                if (hit) begin
                    if (idx == 4'd0) begin
                        if (s2) act <= 1'b0;
                    end else if (idx <= nb) begin
                        sh[3'(idx - 4'd1)] <= s2;
                    end else if (fcfg.par_en && idx == nb + 4'd1) begin
                        perr_acc <= (s2 != ((^sh) ^ ~fcfg.par_even));
                    end else begin
                        if (!s2) serr_acc <= 1'b1;
                        if (idx == last) begin
                            act  <= 1'b0;
                            done <= 1'b1;
                            data <= sh;
                            perr <= perr_acc;
                            serr <= serr_acc | !s2;
                        end
                    end
                end
            end
        end
    end

    a_r5_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (act && idx == 4'd0 && hit && s2) |=> !act);
endmodule

// File: rtl/sio_uart.sv
// Serial transceiver top: register port, two character queues, transmit and receive
// shifters, and the seven-source pending/interrupt logic.
// Assumes register reads are answered one cycle after the strobe.
module sio_uart #(
    parameter int FIFO_DEPTH = 16,
    parameter int CW         = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        ser_tx,
    input  logic        ser_rx,
    output logic        irq0,
    output logic        irq1
);
    import sio_pkg::*;

    logic [CW-1:0]      baud, samp;
    logic               g_en, rx_en, tx_en;
    frame_cfg_t         fcfg;
    logic [NUM_IRQ-1:0] ien0, ien1, pend, ev, clr, setw;
    logic [7:0]         last_rx, tx_head, rx_head, rx_data;
    logic               tx_empty, tx_full, rx_empty, rx_full;
    logic               tx_push, tx_take, rx_pop, rx_done, rx_perr, rx_serr;
    logic               wr_txd, rd_rxd;
    logic [31:0]        rd_mux;

    assign wr_txd  = reg_wr && reg_addr == OFF_TXD;
    assign rd_rxd  = reg_rd && reg_addr == OFF_RXD;
    assign tx_push = wr_txd && !tx_full;
    assign rx_pop  = rd_rxd && !rx_empty;

    sio_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) tx_q (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(reg_wdata[7:0]),
        .pop(tx_take), .dout(tx_head), .empty(tx_empty), .full(tx_full));

    sio_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) rx_q (
        .clk(clk), .rst_n(rst_n), .push(rx_done && !rx_full), .din(rx_data),
        .pop(rx_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full));

    sio_tx #(.CW(CW)) tx_i (
        .clk(clk), .rst_n(rst_n), .en(g_en && tx_en), .baud(baud), .fcfg(fcfg),
        .have_data(!tx_empty), .data(tx_head), .take(tx_take), .line(ser_tx));

    sio_rx #(.CW(CW)) rx_i (
        .clk(clk), .rst_n(rst_n), .en(g_en && rx_en), .baud(baud), .samp(samp),
        .fcfg(fcfg), .line(ser_rx), .done(rx_done), .data(rx_data),
        .perr(rx_perr), .serr(rx_serr));

    // Configuration, sample point and interrupt masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            baud  <= '0;
            g_en  <= 1'b0;
            rx_en <= 1'b0;
            tx_en <= 1'b0;
            fcfg  <= '0;
            samp  <= CW'(7);
            ien0  <= '0;
            ien1  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                OFF_CFG: begin
                    baud  <= reg_wdata[31:8];
                    g_en  <= reg_wdata[7];
                    rx_en <= reg_wdata[6];
                    tx_en <= reg_wdata[5];
                    fcfg  <= '{par_en: reg_wdata[4], par_even: reg_wdata[3],
                               two_stop: reg_wdata[2], len: reg_wdata[1:0]};
                end
                OFF_SAMP: samp <= reg_wdata[CW-1:0];
                OFF_IEN0: ien0 <= reg_wdata[NUM_IRQ-1:0];
                OFF_IEN1: ien1 <= reg_wdata[NUM_IRQ-1:0];
                default: ;
            endcase
        end
    end

    // Interrupt events, software set and clear.
    always_comb begin
        ev            = '0;
        ev[IRQ_TXOVR] = wr_txd && tx_full;
        ev[IRQ_STOPE] = rx_done && rx_serr;
        ev[IRQ_PARE]  = rx_done && rx_perr;
        ev[IRQ_RXOVR] = rx_done && rx_full;
        ev[IRQ_RXUND] = rd_rxd && rx_empty;
        ev[IRQ_TXE]   = tx_empty;
        ev[IRQ_RXNE]  = !rx_empty;
        clr  = (reg_wr && reg_addr == OFF_PCLR) ? reg_wdata[NUM_IRQ-1:0] : '0;
        setw = (reg_wr && reg_addr == OFF_PSET) ? reg_wdata[NUM_IRQ-1:0] : '0;
    end

    // Pending register: events win over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | ev | setw;
    end

    assign irq0 = |(pend & ien0);
    assign irq1 = |(pend & ien1);

    // Read data selection.
    always_comb begin
        case (reg_addr)
            OFF_CFG:  rd_mux = {baud, g_en, rx_en, tx_en, fcfg.par_en, fcfg.par_even,
                                fcfg.two_stop, fcfg.len};
            OFF_SAMP: rd_mux = 32'(samp);
            OFF_RXD:  rd_mux = {24'h0, rx_empty ? last_rx : rx_head};
            OFF_STAT: rd_mux = {28'h0, tx_empty, tx_full, rx_empty, rx_full};
            OFF_IEN0: rd_mux = 32'(ien0);
            OFF_IEN1: rd_mux = 32'(ien1);
            OFF_PCLR, OFF_PSET: rd_mux = 32'(pend);
            OFF_MSKD: rd_mux = 32'(pend & (ien0 | ien1));
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data and last-taken character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            last_rx   <= '0;
        end else begin
            if (reg_rd) reg_rdata <= rd_mux;
            if (rx_pop) last_rx <= rx_head;
        end
    end

    a_r8_tx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txd && tx_full) |=> pend[IRQ_TXOVR]);
    a_r9_rx_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxd && rx_empty) |=> pend[IRQ_RXUND]);
    a_r10_rx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_full) |=> pend[IRQ_RXOVR]);
    a_r12_rxne_level: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_empty |=> pend[IRQ_RXNE]);
endmodule

// File: tb/sio_uart_tb_top.sv
// Self-checking bench: sweeps frame formats in both directions, then exercises queue
// limits, error flags, the sample point and the interrupt routing.
module sio_uart_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ser_tx, irq0, irq1;
    logic        ser_rx = 1'b1;
    int          nchk = 0, nfail = 0;

    always #2 clk = ~clk;

    sio_uart dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_tx(ser_tx), .ser_rx(ser_rx),
        .irq0(irq0), .irq1(irq1));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] mkcfg(input int baud, input int len, input int pe,
                                          input int ev, input int s2, input int gen);
        return (32'(baud) << 8) | (32'(gen) << 7) | 32'h60 | (32'(pe) << 4) |
               (32'(ev) << 3) | (32'(s2) << 2) | 32'(len);
    endfunction

    // Expected line bits of one frame, bit 0 first; n returns the bit count.
    function automatic logic [11:0] expframe(input logic [7:0] d, input int len, input int pe,
                                             input int ev, input int s2, output int n);
        logic [11:0] f = '1;
        int nb = 5 + len;
        int ones = 0;
        f[0] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            f[1 + i] = d[i];
            ones += int'(d[i]);
        end
        if (pe != 0) f[1 + nb] = (ev != 0) ? logic'(ones % 2) : logic'((ones + 1) % 2);
        n = 2 + nb + pe + s2;
        return f;
    endfunction

    // Capture n bits of a transmitted frame at mid-bit.
    task automatic cap(input int baud, input int n, output logic [11:0] v);
        v = '1;
        @(negedge ser_tx);
        repeat (baud / 2) @(negedge clk);
        v[0] = ser_tx;
        for (int k = 1; k < n; k++) begin
            repeat (baud) @(negedge clk);
            v[k] = ser_tx;
        end
    endtask

    // Drive a frame on the receive line; glitch inverts data/parity bits early in each period.
    task automatic send(input logic [7:0] d, input int len, input int pe, input int ev,
                        input int s2, input int baud, input int flip, input int badstop,
                        input int glitch);
        int n;
        int nb = 5 + len;
        logic [11:0] f = expframe(d, len, pe, ev, s2, n);
        if (flip != 0) f[1 + nb] = ~f[1 + nb];
        if (badstop != 0) f[1 + nb + pe] = 1'b0;
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < baud; c++) begin
                @(negedge clk);
                ser_rx = (k >= 1 && k <= nb + pe && c < glitch) ? ~f[k] : f[k];
            end
        end
        @(negedge clk);
        ser_rx = 1'b1;
        repeat (baud) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        logic [11:0] v, e;
        int n;
        logic [7:0] d;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state.
        rd(8'h00, r); chk("R1 reset cfg", r, 32'h0);
        rd(8'h08, r); chk("R5 reset sample", r, 32'd7);
        rd(8'h18, r); chk("R6 reset status", r, 32'hA);
        rd(8'h24, r); chk("R12 reset pending", r, 32'h20);
        chk("R2 idle line", 32'(ser_tx), 32'h1);
        chk("R12 reset irq0", 32'(irq0), 32'h0);
        wr(8'h08, 32'd8);

        // Transmit sweep over every format.
        for (int len = 0; len < 4; len++)
            for (int pm = 0; pm < 3; pm++)
                for (int s2 = 0; s2 < 2; s2++) begin
                    d = 8'((len * 53 + pm * 29 + s2 * 101 + 8'hA5) & 8'hFF);
                    wr(8'h00, mkcfg(16, len, pm != 0, pm == 2, s2, 1));
                    if (len == 0 && pm == 0 && s2 == 0) begin
                        rd(8'h00, r); chk("R1 cfg readback", r, mkcfg(16, 0, 0, 0, 0, 1));
                    end
                    e = expframe(d, len, pm != 0 ? 1 : 0, pm == 2 ? 1 : 0, s2, n);
                    wr(8'h10, 32'(d));
                    cap(16, n, v);
                    chk($sformatf("R2 R3 R4 tx frame len%0d par%0d stop%0d", len, pm, s2),
                        32'(v) & ((32'd1 << n) - 1), 32'(e) & ((32'd1 << n) - 1));
                end

        // Other bit period.
        wr(8'h00, mkcfg(11, 3, 0, 0, 0, 1));
        e = expframe(8'h3C, 3, 0, 0, 0, n);
        wr(8'h10, 32'h3C);
        cap(11, n, v);
        chk("R1 tx period 11", 32'(v) & 32'h3FF, 32'(e) & 32'h3FF);
        wr(8'h08, 32'd5);
        send(8'hC3, 3, 0, 0, 0, 11, 0, 0, 0);
        rd(8'h14, r); chk("R1 rx period 11", r, 32'hC3);
        wr(8'h08, 32'd8);

        // Receive sweep over every format.
        for (int len = 0; len < 4; len++)
            for (int pm = 0; pm < 3; pm++)
                for (int s2 = 0; s2 < 2; s2++) begin
                    d = 8'((len * 71 + pm * 37 + s2 * 90 + 8'h5A) & 8'hFF);
                    wr(8'h00, mkcfg(16, len, pm != 0, pm == 2, s2, 1));
                    wr(8'h24, 32'h7F);
                    send(d, len, pm != 0 ? 1 : 0, pm == 2 ? 1 : 0, s2, 16, 0, 0, 0);
                    rd(8'h14, r);
                    chk($sformatf("R5 rx data len%0d par%0d stop%0d", len, pm, s2),
                        r, 32'(d & (8'hFF >> (3 - len))));
                    rd(8'h24, r);
                    chk("R11 no error flags", r & 32'h6, 32'h0);
                end

        // Parity and stop errors.
        wr(8'h00, mkcfg(16, 3, 1, 1, 0, 1));
        wr(8'h24, 32'h7F);
        send(8'h96, 3, 1, 1, 0, 16, 1, 0, 0);
        rd(8'h24, r); chk("R11 parity error flag", r & 32'h6, 32'h4);
        rd(8'h14, r); chk("R11 char kept on parity error", r, 32'h96);
        wr(8'h00, mkcfg(16, 3, 0, 0, 0, 1));
        wr(8'h24, 32'h7F);
        send(8'h2B, 3, 0, 0, 0, 16, 0, 1, 0);
        rd(8'h24, r); chk("R11 stop error flag", r & 32'h6, 32'h2);
        rd(8'h14, r); chk("R11 char kept on stop error", r, 32'h2B);

        // Sample point: bits wrong for the first 10 clocks of each period.
        wr(8'h08, 32'd12);
        send(8'hB4, 3, 0, 0, 0, 16, 0, 0, 10);
        rd(8'h14, r); chk("R5 late sample point", r, 32'hB4);
        wr(8'h08, 32'd8);

        // False start: short low pulse.
        rd(8'h18, r);
        chk("R5 empty before glitch", r & 32'h2, 32'h2);
        @(negedge clk); ser_rx = 1'b0;
        repeat (4) @(negedge clk); ser_rx = 1'b1;
        repeat (40) @(negedge clk);
        rd(8'h18, r); chk("R5 false start rejected", r & 32'h2, 32'h2);
        send(8'h71, 3, 0, 0, 0, 16, 0, 0, 0);
        rd(8'h14, r); chk("R5 frame after false start", r, 32'h71);

        // Receive disabled.
        wr(8'h00, mkcfg(16, 3, 0, 0, 0, 1) & ~32'h40);
        send(8'h55, 3, 0, 0, 0, 16, 0, 0, 0);
        rd(8'h18, r); chk("R13 rx disabled ignores line", r & 32'h3, 32'h2);

        // Transmit queue fill with global enable off.
        wr(8'h00, mkcfg(16, 3, 0, 0, 0, 0));
        wr(8'h24, 32'h7F);
        for (int i = 0; i < 16; i++) wr(8'h10, 32'((i * 7 + 3) & 8'hFF));
        rd(8'h18, r); chk("R6 R7 tx full status", r & 32'hC, 32'h4);
        rd(8'h24, r); chk("R8 no overrun yet", r & 32'h1, 32'h0);
        wr(8'h10, 32'hEE);
        rd(8'h24, r); chk("R8 tx overrun flag", r & 32'h1, 32'h1);
        chk("R13 line high while disabled", 32'(ser_tx), 32'h1);
        wr(8'h00, mkcfg(16, 3, 0, 0, 0, 1));
        for (int i = 0; i < 16; i++) begin
            e = expframe(8'((i * 7 + 3) & 8'hFF), 3, 0, 0, 0, n);
            cap(16, n, v);
            chk($sformatf("R7 R8 tx order %0d", i), 32'(v) & 32'h3FF, 32'(e) & 32'h3FF);
        end
        repeat (20) @(negedge clk);
        rd(8'h18, r); chk("R6 tx empty after drain", r & 32'hC, 32'h8);
        chk("R8 dropped byte not sent", 32'(ser_tx), 32'h1);

        // Receive queue overrun and underrun.
        wr(8'h24, 32'h7F);
        for (int i = 0; i < 16; i++) send(8'(8'h10 + i), 3, 0, 0, 0, 16, 0, 0, 0);
        rd(8'h18, r); chk("R6 R7 rx full status", r & 32'h3, 32'h1);
        rd(8'h24, r); chk("R10 no overrun yet", r & 32'h8, 32'h0);
        send(8'hAB, 3, 0, 0, 0, 16, 0, 0, 0);
        rd(8'h24, r); chk("R10 rx overrun flag", r & 32'h8, 32'h8);
        for (int i = 0; i < 16; i++) begin
            rd(8'h14, r);
            chk($sformatf("R7 R10 rx order %0d", i), r, 32'(8'h10 + i));
        end
        rd(8'h24, r); chk("R9 no underrun yet", r & 32'h10, 32'h0);
        rd(8'h14, r); chk("R9 stale data on empty read", r, 32'h1F);
        rd(8'h24, r); chk("R9 rx underrun flag", r & 32'h10, 32'h10);

        // Interrupt routing.
        wr(8'h24, 32'h7F);
        rd(8'h24, r); chk("R12 clear leaves tx-empty level", r, 32'h20);
        wr(8'h1C, 32'h40);
        wr(8'h20, 32'h04);
        chk("R12 irq0 quiet", 32'(irq0), 32'h0);
        chk("R12 irq1 quiet", 32'(irq1), 32'h0);
        send(8'h3E, 3, 0, 0, 0, 16, 0, 0, 0);
        chk("R12 irq0 on rx non-empty", 32'(irq0), 32'h1);
        chk("R12 irq1 still quiet", 32'(irq1), 32'h0);
        wr(8'h28, 32'h04);
        chk("R12 irq1 after software set", 32'(irq1), 32'h1);
        rd(8'h2C, r); chk("R12 masked pending", r, 32'h44);
        rd(8'h14, r); chk("R12 rx char", r, 32'h3E);
        wr(8'h24, 32'h44);
        chk("R12 irq0 cleared", 32'(irq0), 32'h0);
        chk("R12 irq1 cleared", 32'(irq1), 32'h0);
        rd(8'h28, r); chk("R12 pending after clear", r, 32'h20);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule